// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the external bus timing of an 8-bit microcontroller core. The core fetches code from external program memory and reads or writes external data memory. The oscillator clock drives the block directly. A machine cycle is twelve clocks, split into two halves of six clocks. In the usual case each half is an instruction fetch. The half opens with an address-latch pulse, then puts out the low address byte on a shared address/data port. It ends with a low-going program-store strobe while the port floats to receive the opcode byte.

A data request turns two machine cycles into a data access. The fetch in the second half of the first cycle is replaced by a latch pulse for the data address. The read or write strobe then runs in the first half of the next cycle. In that half there is no latch pulse and no program-store strobe. The high address port normally shows the high byte of the fetch address. During the data window it shows the high byte of the data address when the access uses a 16-bit pointer. It shows the live port-register value when the access uses an 8-bit register address.

The reset input is filtered. It takes effect only after it has been held high for two full machine cycles. The sequence then restarts at the first clock of a fetch cycle.

Top module: `extBusSequencer`

## Requirements
- R1: With clock index t = 0..11 counted from reset release, `ale` is high at t = 0..2 and t = 6..8 of every machine cycle, except as stated in R2.
- R2: A data access covers two machine cycles, called A and B. The ALE pulse at t = 0..2 of cycle B is omitted, and it is the only one dropped per access.
- R3: When the cycle is an external fetch cycle, `psenN` is low at t = 4..5 of each fetching half and high at all other times. A half is a fetching half unless it is the second half of A or the first half of B.
- R4: `psenN` stays high during the second half of cycle A and the first half of cycle B, so each access omits two activations.
- R5: A machine cycle whose sampled `fetchReq` was 0 is an internal fetch cycle. In such a cycle `psenN` never goes low and the low port is not driven for a fetch.
- R6: On the low port (`adOe` = 1 means driven), the rules are these. During an external fetch, the fetch address low byte is driven at half-offsets 0..3 and the port floats at 4..5. The data address low byte is driven at t = 6..9 of A. For a write, the write data is driven from t = 10 of A through t = 5 of B. For a read, the port floats over that same span. `adOut` is 0 whenever the port is not driven.
- R7: `hiOut` carries the fetch address high byte during fetch halves. For a 16-bit access (`dataShort` = 0) it carries the data address high byte from t = 6 of A through t = 5 of B.
- R8: For an 8-bit access (`dataShort` = 1), `hiOut` follows the live `p2Reg` input during that same window.
- R9: `rdN` (read, `dataWrite` = 0) or `wrN` (write, `dataWrite` = 1) is low at t = 0..4 of cycle B. The two are never low together, and neither is low while `psenN` is low.
- R10: On a read, `adIn` is captured at the clock edge that ends t = 4 of B. It appears on `rdData` from t = 5 of B, with `rdValid` high for that one clock.
- R11: Once `rst` has been high on 24 consecutive clock edges, all strobes go inactive: `ale` = 0, `psenN`/`rdN`/`wrN` = 1, `adOe` = 0, and `hiOut`, `rdData` and `rdValid` read 0. This holds until the first edge with `rst` low. The next clock is t = 0 of a non-access cycle.
- R12: A `rst` pulse that is high for fewer than 24 consecutive edges has no effect on the sequence.
- R13: `fetchReq`, `dataReq`, `dataWrite`, `dataShort`, `dataAddr` and `wrData` are sampled on the edge that ends t = 11. `dataReq` is ignored on the edge that ends cycle A. `fetchAddr` is sampled on the edges that end t = 11 and t = 5, except in cycle A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Reset request, filtered over two machine cycles |
| fetchReq | input | 1 | Next cycle fetches from external program memory |
| fetchAddr | input | 16 | Program fetch address |
| dataReq | input | 1 | Start an external data access in the next cycle |
| dataWrite | input | 1 | Access is a write (1) or a read (0) |
| dataShort | input | 1 | Access uses an 8-bit register address |
| dataAddr | input | 16 | Data access address |
| wrData | input | 8 | Write data |
| p2Reg | input | 8 | High-port register contents |
| adIn | input | 8 | Low port input value |
| ale | output | 1 | Address latch enable, active high |
| psenN | output | 1 | Program store enable, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| adOut | output | 8 | Low port output value |
| adOe | output | 1 | Low port drive enable |
| hiOut | output | 8 | High port output value |
| rdData | output | 8 | Last captured read byte |
| rdValid | output | 1 | One-clock pulse when rdData is new |

## Verification
The properties assume only that `rst` is high long enough to clear the block before any strobe relation is trusted. They are disabled while `rst` is high, because a filtered reset may cut a cycle partway through. Apart from that they rely on nothing about the request inputs. The stimulus lets every input change on every clock with random values and random request patterns, including requests held high across whole accesses. That exercises the sampling windows from every phase. Reset pulses just under and well over the filter length are applied in the middle of traffic.

// File: rtl/extBusPkg.sv
package extBusPkg;
  localparam int CYC_CLKS = 12;
  localparam int HALF_CLKS = CYC_CLKS / 2;

  typedef enum logic [1:0] {
    CYC_NORM = 2'd0,
    CYC_ACCA = 2'd1,
    CYC_ACCB = 2'd2
  } cycKind_e;

  typedef struct packed {
    logic idle;
    logic aleOn;
    logic psenOn;
    logic rdOn;
    logic wrOn;
    logic drvFetchLo;
    logic drvDataAddr;
    logic drvWrData;
    logic hiData;
    logic hiPort;
    logic latchFetch;
    logic latchData;
    logic capture;
  } busCtl_t;
endpackage

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import extBusPkg::*;
#(
  parameter int RST_CYCLES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    fetchReq,
  input  logic    dataReq,
  input  logic    dataWrite,
  input  logic    dataShort,
  output busCtl_t ctl,
  output logic    holdRst
);
  localparam int RST_CLKS = RST_CYCLES * CYC_CLKS;
  localparam int RCW = $clog2(RST_CLKS + 1);
  localparam int TW = $clog2(CYC_CLKS);
  localparam logic [RCW-1:0] RST_LIM = RCW'(RST_CLKS);
  localparam logic [TW-1:0] T_LAST = TW'(CYC_CLKS - 1);
  localparam logic [TW-1:0] T_MID = TW'(HALF_CLKS - 1);
  localparam logic [TW-1:0] T_HALF = TW'(HALF_CLKS);

  logic [RCW-1:0] rstCnt;
  logic [TW-1:0]  tick;
  cycKind_e       kind;
  logic           fetchExt;
  logic           accWrite;
  logic           accShort;

  logic           firstHalf;
  logic [TW-1:0]  tin;
  logic           fetchHalf;
  logic           inAcc;
  logic           takeData;

  assign holdRst = (rstCnt >= RST_LIM);

  always_ff @(posedge clk) begin
    if (rst) rstCnt <= holdRst ? RST_LIM : rstCnt + 1'b1;
    else     rstCnt <= '0;
  end

  assign takeData = (tick == T_LAST) && (kind != CYC_ACCA) && dataReq;

  always_ff @(posedge clk) begin
    if (holdRst) begin
      tick     <= '0;
      kind     <= CYC_NORM;
      fetchExt <= fetchReq;
      accWrite <= 1'b0;
      accShort <= 1'b0;
    end else begin
      tick <= (tick == T_LAST) ? '0 : tick + 1'b1;
      if (tick == T_LAST) begin
        fetchExt <= fetchReq;
        if (kind == CYC_ACCA)  kind <= CYC_ACCB;
        else if (dataReq)      kind <= CYC_ACCA;
        else                   kind <= CYC_NORM;
      end
      if (takeData) begin
        accWrite <= dataWrite;
        accShort <= dataShort;
      end
    end
  end

  always_comb begin
    firstHalf = (tick < T_HALF);
    tin       = firstHalf ? tick : tick - T_HALF;
    fetchHalf = firstHalf ? (kind != CYC_ACCB) : (kind != CYC_ACCA);
    inAcc     = (kind == CYC_ACCA && !firstHalf) || (kind == CYC_ACCB && firstHalf);

    ctl.idle        = holdRst;
    ctl.aleOn       = !holdRst && !(kind == CYC_ACCB && firstHalf) && (tin <= TW'(2));
    ctl.psenOn      = !holdRst && fetchExt && fetchHalf && (tin >= TW'(4));
    ctl.drvFetchLo  = !holdRst && fetchExt && fetchHalf && (tin <= TW'(3));
    ctl.drvDataAddr = !holdRst && (kind == CYC_ACCA) && !firstHalf && (tin <= TW'(3));
    ctl.drvWrData   = !holdRst && accWrite &&
                      (((kind == CYC_ACCA) && !firstHalf && (tin >= TW'(4))) ||
                       ((kind == CYC_ACCB) && firstHalf));
    ctl.rdOn        = !holdRst && (kind == CYC_ACCB) && firstHalf && !accWrite && (tin <= TW'(4));
    ctl.wrOn        = !holdRst && (kind == CYC_ACCB) && firstHalf && accWrite && (tin <= TW'(4));
    ctl.hiData      = !holdRst && inAcc && !accShort;
    ctl.hiPort      = !holdRst && inAcc && accShort;
    ctl.latchFetch  = holdRst ||
                      (((tick == T_LAST) || (tick == T_MID)) && (kind != CYC_ACCA));
    ctl.latchData   = !holdRst && takeData;
    ctl.capture     = ctl.rdOn && (tin == TW'(4));
  end
endmodule

// File: rtl/extBusPath.sv
module extBusPath
  import extBusPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] p2Reg,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ADDR_W-1:0] fetchLat;
  logic [ADDR_W-1:0] dataLat;
  logic [DATA_W-1:0] wdLat;

  always_ff @(posedge clk) begin
    if (ctl.latchFetch) fetchLat <= fetchAddr;
    if (ctl.latchData) begin
      dataLat <= dataAddr;
      wdLat   <= wrData;
    end
    if (ctl.idle) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= adIn;
    end
  end

  always_comb begin
    adOe = ctl.drvFetchLo || ctl.drvDataAddr || ctl.drvWrData;
    if (ctl.drvFetchLo)       adOut = fetchLat[DATA_W-1:0];
    else if (ctl.drvDataAddr) adOut = dataLat[DATA_W-1:0];
    else if (ctl.drvWrData)   adOut = wdLat;
    else                      adOut = '0;

    if (ctl.idle)        hiOut = '0;
    else if (ctl.hiPort) hiOut = p2Reg;
    else if (ctl.hiData) hiOut = dataLat[ADDR_W-1 -: DATA_W];
    else                 hiOut = fetchLat[ADDR_W-1 -: DATA_W];
  end
endmodule

// File: rtl/extBusSequencer.sv
module extBusSequencer
  import extBusPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W,
  parameter int RST_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              dataReq,
  input  logic              dataWrite,
  input  logic              dataShort,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] p2Reg,
  input  logic [DATA_W-1:0] adIn,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  busCtl_t ctl;
  logic    holdRst;

  extBusCtrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .dataReq(dataReq),
    .dataWrite(dataWrite), .dataShort(dataShort), .ctl(ctl), .holdRst(holdRst)
  );

  extBusPath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .ctl(ctl), .fetchAddr(fetchAddr), .dataAddr(dataAddr),
    .wrData(wrData), .p2Reg(p2Reg), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .hiOut(hiOut), .rdData(rdData), .rdValid(rdValid)
  );

  assign ale   = ctl.aleOn;
  assign psenN = !ctl.psenOn;
  assign rdN   = !ctl.rdOn;
  assign wrN   = !ctl.wrOn;
endmodule

// File: rtl/extBusChecker.sv
module extBusChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              psenN,
  input logic              rdN,
  input logic              wrN,
  input logic              adOe,
  input logic [DATA_W-1:0] adOut
);
  assert_ale_psen_apart_R3: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psenN));

  assert_rd_wr_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));

  assert_data_strobe_no_psen_R9: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> psenN);

  assert_port_floats_in_read_R6: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> !adOe);

  assert_released_before_read_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rdN) |-> $past(!adOe));

  assert_addr_held_past_ale_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(ale) && adOe) |-> $stable(adOut));

  assert_ale_width_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);

  assert_rd_width_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rdN) |=> !rdN);
endmodule

bind extBusSequencer extBusChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
  .adOe(adOe), .adOut(adOut)
);

// File: tb/extBusSequencer_bench.sv
module extBusSequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        fetchReq = 1'b1;
  logic [15:0] fetchAddr = '0;
  logic        dataReq = 1'b0;
  logic        dataWrite = 1'b0;
  logic        dataShort = 1'b0;
  logic [15:0] dataAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  p2Reg = '0;
  logic [7:0]  adIn = '0;
  logic        ale, psenN, rdN, wrN, adOe, rdValid;
  logic [7:0]  adOut, hiOut, rdData;

  always #5 clk = ~clk;

  extBusSequencer u_extBusSequencer (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .dataReq(dataReq), .dataWrite(dataWrite), .dataShort(dataShort),
    .dataAddr(dataAddr), .wrData(wrData), .p2Reg(p2Reg), .adIn(adIn),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN), .adOut(adOut),
    .adOe(adOe), .hiOut(hiOut), .rdData(rdData), .rdValid(rdValid)
  );

  int checks = 0;
  int errors = 0;
  bit armed = 0;
  bit done = 0;
  int mode = 0;

  // behavioural reference state: 0 normal, 1 access A, 2 access B
  int mt = 0, mkind = 0, rcnt = 0;
  int mext = 0, mw = 0, ms = 0, mfa = 0, mda = 0, mwd = 0, mrd = 0, mrv = 0;

  always @(posedge clk) begin
    bit hold;
    bit cap;
    hold = (rcnt >= 24);
    cap = !hold && mkind == 2 && mt == 4 && mw == 0;
    rcnt <= rst ? ((rcnt >= 24) ? 24 : rcnt + 1) : 0;
    if (hold) begin
      mt <= 0; mkind <= 0; mext <= fetchReq; mfa <= fetchAddr;
      mw <= 0; ms <= 0; mrd <= 0; mrv <= 0;
    end else begin
      mrv <= cap;
      if (cap) mrd <= adIn;
      if ((mt == 11 || mt == 5) && mkind != 1) mfa <= fetchAddr;
      if (mt == 11) begin
        mext <= fetchReq;
        if (mkind == 1) mkind <= 2;
        else if (dataReq) begin
          mkind <= 1; mda <= dataAddr; mwd <= wrData; mw <= dataWrite; ms <= dataShort;
        end else mkind <= 0;
      end
      mt <= (mt == 11) ? 0 : mt + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0d kind=%0d actual=%0h expected=%0h", req, mt, mkind, act, exp);
    end
  endtask

  task automatic compareAll();
    bit hold, fh, fhalf, inAcc, dFetch, dAddr, dWd;
    int tin, eAd, eHi;
    string aleTag, psTag, hiTag;
    hold = (rcnt >= 24);
    tin = mt % 6;
    fh = (mt < 6);
    fhalf = fh ? (mkind != 2) : (mkind != 1);
    inAcc = (mkind == 1 && !fh) || (mkind == 2 && fh);
    dFetch = !hold && mext != 0 && fhalf && tin <= 3;
    dAddr = !hold && mkind == 1 && !fh && tin <= 3;
    dWd = !hold && mw != 0 && ((mkind == 1 && !fh && tin >= 4) || (mkind == 2 && fh));
    eAd = dFetch ? (mfa & 255) : dAddr ? (mda & 255) : dWd ? mwd : 0;
    eHi = hold ? 0 : inAcc ? (ms != 0 ? int'(p2Reg) : (mda >> 8)) : (mfa >> 8);
    aleTag = hold ? "R11" : (mkind == 2 && fh) ? "R2" : "R1";
    psTag = hold ? "R11" : !fhalf ? "R4" : (mext == 0) ? "R5" : "R3";
    hiTag = hold ? "R11" : inAcc ? (ms != 0 ? "R8" : "R7") : "R7/R13";
    chk(aleTag, ale, (!hold && !(mkind == 2 && fh) && tin <= 2));
    chk(psTag, psenN, !(!hold && mext != 0 && fhalf && tin >= 4));
    chk("R9", rdN, !(!hold && mkind == 2 && fh && mw == 0 && tin <= 4));
    chk("R9", wrN, !(!hold && mkind == 2 && fh && mw != 0 && tin <= 4));
    chk("R6", adOe, dFetch || dAddr || dWd);
    chk("R6/R13", adOut, eAd);
    chk(hiTag, hiOut, eHi);
    chk("R10", rdData, mrd);
    chk("R10", rdValid, mrv);
  endtask

  task automatic step(bit r);
    @(negedge clk);
    if (rcnt >= 24) armed = 1;
    if (armed) compareAll();
    rst = r;
    fetchAddr = 16'($urandom);
    dataAddr = 16'($urandom);
    wrData = 8'($urandom);
    p2Reg = 8'($urandom);
    adIn = 8'($urandom);
    dataWrite = 1'($urandom);
    dataShort = 1'($urandom);
    case (mode)
      1: begin dataReq = 1'b1; fetchReq = 1'b1; end
      2: begin dataReq = ($urandom % 3) == 0; fetchReq = 1'b0; end
      default: begin dataReq = ($urandom % 3) == 0; fetchReq = ($urandom % 8) != 0; end
    endcase
  endtask

  initial begin
    repeat (3) step(1'b0);
    repeat (26) step(1'b1);
    @(negedge clk);
    // R11: strobes idle while the filtered reset is active
    chk("R11", ale, 0); chk("R11", psenN, 1); chk("R11", adOe, 0); chk("R11", rdValid, 0);
    step(1'b0);
    @(negedge clk);
    // R11: first clock after release is t=0 of a normal cycle with ALE high
    chk("R11", ale, 1);
    chk("R11", mt, 0);
    repeat (1500) step(1'b0);
    mode = 1; repeat (300) step(1'b0);
    mode = 2; repeat (300) step(1'b0);
    mode = 0; repeat (40) step(1'b0);
    repeat (23) step(1'b1);
    step(1'b0);
    // R12: a 23-edge pulse must not have reset the sequence
    chk("R12", rcnt < 24, 1);
    repeat (200) step(1'b0);
    repeat (30) step(1'b1);
    repeat (300) step(1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule